// File: doc/BRIEF.md
# Cascaded Sixteen-Line Interrupt Controller

This block collects sixteen interrupt request lines in two banks of eight: a primary bank (lines 0 to 7) and a secondary bank (lines 8 to 15). The secondary bank feeds its combined request into primary line 2, so the two banks form one priority chain. A small register bus gives each bank a mask byte, a trigger-select byte and a command port. The command port accepts end-of-interrupt writes.

A line with an unmasked request that no in-service line in its bank blocks raises `int_out`. When the CPU pulses `int_ack`, the winning line moves into service, its latched edge request clears, and its vector appears one cycle later for one cycle. The line stays in service until software writes an end-of-interrupt to its bank. A line in the secondary bank needs two writes: one to the secondary command port, then one to the primary command port.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After reset, address 0 (primary mask) reads 0xFB, address 1 (secondary mask) reads 0xFF, and addresses 2 and 3 (trigger select) read 0x00. `int_out` and `vec_valid` are low.
- R2: In the mask bytes at address 0 (lines 0-7) and address 1 (lines 8-15), bit n covers line 8*bank+n. A 1 keeps the line from reaching `int_out`, and a 0 lets it through. A request that arrives while its line is masked is kept and appears once the line is unmasked.
- R3: The trigger-select bytes are at address 2 (lines 0-7) and address 3 (lines 8-15). A 1 selects level mode and a 0 selects edge mode. Lines 0, 1, 2, 8 and 13 always read back 0, so writing 0xFF reads back 0xF8 and 0xDE.
- R4: In edge mode, a rising input latches a request. The request stays after the input falls and clears when the line is acknowledged.
- R5: In level mode, a line requests only while its input is high. Nothing is latched, so a level request that falls before acknowledge leaves `int_out` low.
- R6: One cycle after an accepted acknowledge, `vec_valid` is high for one cycle and `vec_out` = 0x800 + (line << 4).
- R7: Priority from highest to lowest is 0, 1, 8..15, 3..7.
- R8: An in-service line blocks lines of equal and lower priority in its own bank. Higher-priority lines can still interrupt.
- R9: A write to address 4 (primary command) or address 5 (secondary command) whose bits 7:3 are 00100 clears that bank's highest-priority in-service bit. Bits 2:0 are ignored, and any other command value has no effect.
- R10: With primary mask bit 2 set, lines 8-15 cannot raise `int_out`. A secondary line in service also holds primary line 2 in service, so further secondary requests stay blocked until both end-of-interrupt writes are done.
- R11: An acknowledge while `int_out` is low produces no vector and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 16 | Request lines 0-15 (line 2 input is unused; the cascade drives it) |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address for read and write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (mask and trigger bytes) |
| int_out | output | 1 | Interrupt request to the CPU |
| int_ack | input | 1 | CPU acknowledge |
| vec_valid | output | 1 | Vector strobe, one cycle |
| vec_out | output | 16 | Vector of the acknowledged line |

## Verification
The bench builds the block with its default parameters. These are a vector base of 0x800, a shift of four, and a forced-edge set of lines 0, 1, 2, 8 and 13. With these values every expected vector can be written as a literal, and the read-back of 0xF8 and 0xDE shows exactly which bits are forced. This setup lets the bench reach cascade preemption, the two-step end-of-interrupt for secondary lines, nested in-service lines within the primary bank, and level-versus-edge behaviour on the same line.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int BANK_LINES  = 8;
    localparam int NUM_BANKS   = 2;
    localparam int NUM_LINES   = BANK_LINES * NUM_BANKS;
    localparam int IDX_W       = $clog2(BANK_LINES);
    localparam int LINE_W      = $clog2(NUM_LINES);
    localparam int CASCADE_POS = 2;
    localparam int VEC_W       = 16;
    localparam logic [4:0] EOI_TAG = 5'b00100;

    typedef logic [BANK_LINES-1:0] bank_vec_t;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } pick_t;

    typedef enum logic [2:0] {
        A_MASK_P = 3'd0,
        A_MASK_S = 3'd1,
        A_TRIG_P = 3'd2,
        A_TRIG_S = 3'd3,
        A_CMD_P  = 3'd4,
        A_CMD_S  = 3'd5
    } reg_addr_e;

    // lowest set bit wins (lowest index = highest priority)
    function automatic pick_t first_set(input bank_vec_t v);
        pick_t p;
        p = '0;
        for (int i = BANK_LINES - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.hit = 1'b1;
                p.idx = IDX_W'(i);
            end
        end
        return p;
    endfunction

    function automatic logic [VEC_W-1:0] vec_of(input logic [LINE_W-1:0] line,
                                                input logic [VEC_W-1:0] base,
                                                input int shift);
        return base + (VEC_W'(line) << shift);
    endfunction

endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter logic [NUM_LINES-1:0] FORCED_EDGE = 16'h2107
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr,
    input  logic [2:0]           addr,
    input  logic [7:0]           wdata,
    output logic [NUM_LINES-1:0] mask,
    output logic [NUM_LINES-1:0] level_sel,
    output logic                 eoi_p,
    output logic                 eoi_s,
    output logic [7:0]           rdata
);
    localparam logic [NUM_LINES-1:0] MASK_RST = ~(NUM_LINES'(1) << CASCADE_POS);

    logic [NUM_LINES-1:0] mask_q, trig_q;
    logic                 is_eoi;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= MASK_RST;
            trig_q <= '0;
        end else if (wr) begin
            case (reg_addr_e'(addr))
                A_MASK_P: mask_q[BANK_LINES-1:0]         <= wdata;
                A_MASK_S: mask_q[NUM_LINES-1:BANK_LINES] <= wdata;
                A_TRIG_P: trig_q[BANK_LINES-1:0]         <= wdata & ~FORCED_EDGE[BANK_LINES-1:0];
                A_TRIG_S: trig_q[NUM_LINES-1:BANK_LINES] <= wdata & ~FORCED_EDGE[NUM_LINES-1:BANK_LINES];
                default: ;
            endcase
        end
    end

    assign is_eoi = wr && (wdata[7:3] == EOI_TAG);
    assign eoi_p  = is_eoi && (reg_addr_e'(addr) == A_CMD_P);
    assign eoi_s  = is_eoi && (reg_addr_e'(addr) == A_CMD_S);

    always_comb begin
        case (reg_addr_e'(addr))
            A_MASK_P: rdata = mask_q[BANK_LINES-1:0];
            A_MASK_S: rdata = mask_q[NUM_LINES-1:BANK_LINES];
            A_TRIG_P: rdata = trig_q[BANK_LINES-1:0];
            A_TRIG_S: rdata = trig_q[NUM_LINES-1:BANK_LINES];
            default:  rdata = '0;
        endcase
    end

    assign mask      = mask_q;
    assign level_sel = trig_q;
endmodule

// File: rtl/irqc_capture.sv
module irqc_capture
    import irqc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] lines_in,
    input  logic [NUM_LINES-1:0] level_sel,
    input  logic [NUM_LINES-1:0] clr,
    output logic [NUM_LINES-1:0] req_out
);
    logic [NUM_LINES-1:0] prev_q, pend_q;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q[g] <= 1'b0;
                pend_q[g] <= 1'b0;
            end else begin
                prev_q[g] <= lines_in[g];
                if (!level_sel[g] && lines_in[g] && !prev_q[g])
                    pend_q[g] <= 1'b1;
                else if (clr[g] || level_sel[g])
                    pend_q[g] <= 1'b0;
            end
        end
        assign req_out[g] = level_sel[g] ? lines_in[g] : pend_q[g];
    end
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bank_vec_t        req,
    input  logic             take,
    input  logic             eoi,
    output logic             valid,
    output logic [IDX_W-1:0] win,
    output bank_vec_t        isr
);
    bank_vec_t isr_q, elig;
    pick_t     top_isr, pick;

    assign top_isr = first_set(isr_q);

    for (genvar g = 0; g < BANK_LINES; g++) begin : g_elig
        assign elig[g] = req[g] && !(top_isr.hit && (IDX_W'(g) >= top_isr.idx));
    end

    assign pick  = first_set(elig);
    assign valid = pick.hit;
    assign win   = pick.idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            isr_q <= '0;
        end else begin
            bank_vec_t nxt;
            nxt = isr_q;
            if (eoi && top_isr.hit) nxt[top_isr.idx] = 1'b0;
            if (take && pick.hit)   nxt[pick.idx]    = 1'b1;
            isr_q <= nxt;
        end
    end

    assign isr = isr_q;
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl
    import irqc_pkg::*;
#(
    parameter logic [15:0] FORCED_EDGE = 16'h2107,
    parameter logic [15:0] VEC_BASE    = 16'h0800,
    parameter int          VEC_SHIFT   = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] irq_in,
    input  logic        bus_wr,
    input  logic [2:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        int_out,
    input  logic        int_ack,
    output logic        vec_valid,
    output logic [15:0] vec_out
);
    logic [NUM_LINES-1:0] mask_all, level_all, raw_req, clr_line;
    logic                 eoi_p, eoi_s;
    bank_vec_t            p_req, s_req, p_isr, s_isr;
    logic                 p_valid, s_valid, take_p, take_s;
    logic [IDX_W-1:0]     p_win, s_win;
    logic [LINE_W-1:0]    line;
    logic                 vec_valid_q;
    logic [VEC_W-1:0]     vec_q;

    irqc_regs #(.FORCED_EDGE(FORCED_EDGE)) u_regs (
        .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .mask(mask_all), .level_sel(level_all), .eoi_p(eoi_p), .eoi_s(eoi_s),
        .rdata(bus_rdata)
    );

    irqc_capture u_cap (
        .clk(clk), .rst(rst), .lines_in(irq_in), .level_sel(level_all),
        .clr(clr_line), .req_out(raw_req)
    );

    // secondary bank: its own lines
    assign s_req = raw_req[NUM_LINES-1:BANK_LINES] & ~mask_all[NUM_LINES-1:BANK_LINES];

    // primary bank: cascade output replaces line 2
    always_comb begin
        p_req = raw_req[BANK_LINES-1:0] & ~mask_all[BANK_LINES-1:0];
        p_req[CASCADE_POS] = s_valid & ~mask_all[CASCADE_POS];
    end

    assign take_p = int_ack && p_valid;
    assign take_s = take_p && (p_win == IDX_W'(CASCADE_POS));

    irqc_bank u_bank_p (
        .clk(clk), .rst(rst), .req(p_req), .take(take_p), .eoi(eoi_p),
        .valid(p_valid), .win(p_win), .isr(p_isr)
    );

    irqc_bank u_bank_s (
        .clk(clk), .rst(rst), .req(s_req), .take(take_s), .eoi(eoi_s),
        .valid(s_valid), .win(s_win), .isr(s_isr)
    );

    assign line     = (p_win == IDX_W'(CASCADE_POS)) ? {1'b1, s_win} : {1'b0, p_win};
    assign clr_line = take_p ? (NUM_LINES'(1) << line) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_valid_q <= 1'b0;
            vec_q       <= '0;
        end else begin
            vec_valid_q <= take_p;
            if (take_p) vec_q <= vec_of(line, VEC_BASE, VEC_SHIFT);
        end
    end

    assign int_out   = p_valid;
    assign vec_valid = vec_valid_q;
    assign vec_out   = vec_q;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        int_ack,
    input logic        int_out,
    input logic        vec_valid,
    input logic [15:0] vec_out,
    input logic        mask_p2,
    input bank_vec_t   isr_p,
    input bank_vec_t   isr_s
);
    // R6: vector shape 0x800 + line<<4, never line 2
    p_vec_shape_r6: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> (vec_out[15:8] == 8'h08 && vec_out[3:0] == 4'h0 && vec_out[7:4] != 4'h2));

    // R6: accepted acknowledge yields a vector next cycle
    p_ack_vec_r6: assert property (@(posedge clk) disable iff (rst)
        (int_ack && int_out) |=> vec_valid);

    // R11: no vector without an accepted acknowledge
    p_noack_novec_r11: assert property (@(posedge clk) disable iff (rst)
        !(int_ack && int_out) |=> !vec_valid);

    // R10: a secondary vector needs the cascade unmasked when acknowledged
    p_cascade_mask_r10: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && vec_out[7]) |-> !$past(mask_p2));

    // R10: a secondary in-service line implies primary line 2 in service
    p_cascade_isr_r10: assert property (@(posedge clk) disable iff (rst)
        ($rose(|isr_s)) |-> isr_p[CASCADE_POS]);

    // R8: in-service set grows by at most one line per cycle
    p_isr_step_r8: assert property (@(posedge clk) disable iff (rst)
        $countones(isr_p) <= $countones($past(isr_p)) + 1);
endmodule

bind cascade_irq_ctrl irqc_checker u_chk (
    .clk(clk), .rst(rst), .int_ack(int_ack), .int_out(int_out),
    .vec_valid(vec_valid), .vec_out(vec_out), .mask_p2(mask_all[2]),
    .isr_p(p_isr), .isr_s(s_isr)
);

// File: tb/sim_cascade_irq_ctrl.sv
module sim_cascade_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] irq_in = '0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        int_out, int_ack = 1'b0, vec_valid;
    logic [15:0] vec_out;

    int n_chk = 0, n_bad = 0;
    logic [15:0] exp_q[$];

    always #2 clk = ~clk;

    cascade_irq_ctrl u0 (
        .clk(clk), .rst(rst), .irq_in(irq_in), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .int_out(int_out),
        .int_ack(int_ack), .vec_valid(vec_valid), .vec_out(vec_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input string req, input logic [2:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic pulse(input logic [15:0] lines);
        @(negedge clk);
        irq_in = irq_in | lines;
        @(negedge clk);
        irq_in = irq_in & ~lines;
    endtask

    // driver: expected vector goes to the scoreboard
    task automatic ack(input logic [15:0] exp_vec);
        exp_q.push_back(exp_vec);
        @(negedge clk);
        int_ack = 1'b1;
        @(negedge clk);
        int_ack = 1'b0;
        @(negedge clk);
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst && vec_valid) begin
            if (exp_q.size() == 0) begin
                check("R11 unexpected vector", vec_out, 32'hFFFF_FFFF);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                check("R6/R7 vector", vec_out, e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        // R1 reset state
        rd("R1 mask_p", 3'd0, 8'hFB);
        rd("R1 mask_s", 3'd1, 8'hFF);
        rd("R1 trig_p", 3'd2, 8'h00);
        rd("R1 trig_s", 3'd3, 8'h00);
        check("R1 int_out", int_out, 0);
        check("R1 vec_valid", vec_valid, 0);

        // R2 masked request is held, shows after unmask
        pulse(16'h0010);
        idle(1);
        check("R2 masked line 4", int_out, 0);
        wr(3'd0, 8'h00); wr(3'd1, 8'h00);
        rd("R2 mask_p", 3'd0, 8'h00);
        check("R2 unmasked line 4", int_out, 1);
        ack(16'h0840);
        wr(3'd4, 8'h20);
        check("R2 idle", int_out, 0);

        // R3 forced edge bits
        wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
        rd("R3 trig_p", 3'd2, 8'hF8);
        rd("R3 trig_s", 3'd3, 8'hDE);
        wr(3'd2, 8'h00); wr(3'd3, 8'h00);

        // R4 edge latch survives input fall, clears on ack
        pulse(16'h0020);
        idle(2);
        check("R4 latched", int_out, 1);
        ack(16'h0850);
        check("R4 cleared by ack", int_out, 0);
        wr(3'd4, 8'h20);
        check("R4 no re-request", int_out, 0);

        // R7 priority 1 > 8..15 > 3
        pulse(16'h020A);
        check("R7 pending", int_out, 1);
        ack(16'h0810);
        check("R7 lower blocked by line 1", int_out, 0);
        wr(3'd4, 8'h20);
        ack(16'h0890);
        check("R10 line 3 blocked by cascade in service", int_out, 0);
        wr(3'd5, 8'h21); wr(3'd4, 8'h22);
        check("R7 line 3 next", int_out, 1);
        ack(16'h0830);
        wr(3'd4, 8'h20);

        // R8 nesting
        pulse(16'h0020);
        ack(16'h0850);
        pulse(16'h0040);
        check("R8 line 6 blocked by 5", int_out, 0);
        pulse(16'h0010);
        check("R8 line 4 preempts", int_out, 1);
        ack(16'h0840);
        wr(3'd4, 8'h20);
        check("R8 still blocked by 5", int_out, 0);
        wr(3'd4, 8'h20);
        check("R8 line 6 released", int_out, 1);
        ack(16'h0860);
        wr(3'd4, 8'h20);

        // R9 low bits ignored, other commands ignored
        pulse(16'h0080);
        ack(16'h0870);
        pulse(16'h0008);
        ack(16'h0830);
        wr(3'd4, 8'h40);
        pulse(16'h0020);
        check("R9 non-EOI command ignored", int_out, 0);
        wr(3'd4, 8'h27);
        check("R9 EOI cleared line 3 not 7", int_out, 1);
        ack(16'h0850);
        wr(3'd4, 8'h20); wr(3'd4, 8'h20);
        check("R9 all cleared", int_out, 0);

        // R5 level mode
        wr(3'd2, 8'h40);
        @(negedge clk); irq_in[6] = 1'b1;
        idle(1);
        check("R5 level request", int_out, 1);
        ack(16'h0860);
        check("R5 in service", int_out, 0);
        wr(3'd4, 8'h20);
        check("R5 level re-request", int_out, 1);
        irq_in[6] = 1'b0;
        idle(1);
        check("R5 level gone", int_out, 0);
        wr(3'd2, 8'h00);
        check("R5 nothing latched", int_out, 0);

        // R10 cascade mask and two-step EOI
        wr(3'd0, 8'h04);
        pulse(16'h0400);
        idle(1);
        check("R10 cascade masked", int_out, 0);
        wr(3'd0, 8'h00);
        check("R10 cascade unmasked", int_out, 1);
        ack(16'h08A0);
        wr(3'd5, 8'h20);
        pulse(16'h0800);
        check("R10 blocked until primary EOI", int_out, 0);
        wr(3'd4, 8'h20);
        check("R10 released", int_out, 1);
        ack(16'h08B0);
        wr(3'd5, 8'h20); wr(3'd4, 8'h20);
        check("R10 idle", int_out, 0);

        // R11 stray acknowledge
        @(negedge clk); int_ack = 1'b1;
        @(negedge clk); int_ack = 1'b0;
        idle(2);
        check("R11 no request", int_out, 0);
        pulse(16'h0008);
        ack(16'h0830);
        wr(3'd4, 8'h20);
        check("R11 state intact", int_out, 0);

        idle(3);
        check("R6 all vectors seen", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule